// File: doc/BRIEF.md
# Time-Slice Round-Robin Bus Arbiter

This block shares one bus among several masters, each of which has its own request line and grant line. The master that holds grant may keep it across back-to-back transactions for as long as it keeps requesting, but only for a programmable time slice. When the slice is used up and another master is requesting, grant moves on in round-robin order, starting with the agent after the current owner. If nobody else wants the bus, the owner keeps it. Grant is parked on the last owner, so exactly one grant line is high at all times.

The slice length comes from an 8-bit timer register that is written through a write strobe. Its upper five bits give the slice in units of eight bus clocks. Its lower three bits are not stored and always read as zero. The slice counter is loaded from the register each time grant moves, and again on every cycle in which the owner sits parked without a request.

The control is a three-state machine. ST_PARK means the owner is not requesting. ST_HOLD means the owner is inside its slice. ST_OVER means the owner is past its slice and has no competition. The transitions are:

- T_HANDOFF, from any state to ST_HOLD: another agent requests, and either the owner has no request or its slice is done. Grant moves and the counter reloads.
- T_RELEASE, from ST_HOLD or ST_OVER to ST_PARK: the owner drops its request and nobody else is asking.
- T_CLAIM, from ST_PARK to ST_HOLD: the owner requests while slice time remains.
- T_EXPIRE, from ST_PARK or ST_HOLD to ST_OVER: the owner requests, its slice is done, and nobody else is asking.
- T_STAY: the state is kept in every other case.

Top module: `tslice_arbiter`

## Requirements
- R1: While reset (rst_n low) is applied, grant is on agent 0 alone (gnt = 0001 for four agents) and the timer register reads 00h.
- R2: A write with tmr_we high stores bits 7:3 of tmr_wdata at the clock edge. Bits 2:0 of tmr_rdata always read 0, so writing FFh reads back F8h.
- R3: Exactly one bit of gnt is high in every cycle.
- R4: Let L be the slice field times 8 clock cycles. An owner that keeps requesting while others request holds grant for max(L,1) cycles, counted from the edge at which it gained grant.
- R5: When grant moves, it goes to the first requesting agent after the current owner, in ascending index order with wrap-around.
- R6: If the owner's request is low while another agent requests, grant moves at that same clock edge.
- R7: With no other agent requesting, the owner keeps grant. This holds whether or not it requests and whether or not its slice has run out.
- R8: With a slice field of 0, grant rotates every cycle among agents that all request continuously.
- R9: The slice counter reloads from the timer register when grant moves and while the owner is parked without a request. A register write therefore takes effect at the next handoff.
- R10: An owner whose slice has run out loses grant at the first edge at which another agent requests.
- R11: When tmr_we is low, tmr_wdata has no effect on the timer register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_AGENTS | Per-agent bus request |
| gnt | output | N_AGENTS | Per-agent bus grant, one-hot |
| tmr_we | input | 1 | Timer register write strobe |
| tmr_wdata | input | 8 | Timer register write data |
| tmr_rdata | output | 8 | Timer register contents, bits 2:0 zero |

## Verification
The assertions assume that req, tmr_we and tmr_wdata are synchronous to clk, carry no unknown values, and are stable around each rising edge. They also assume that a request is judged only by its sampled value at an edge. The bench meets these assumptions by changing every input on the falling edge only and by sampling outputs one falling edge after the rising edge that acts on them. Each stimulus row holds its request pattern for a counted number of edges. This puts slice expiries, early request drops and register writes on known edges.

// File: rtl/tslice_arb_pkg.sv
package tslice_arb_pkg;

    // Phase of the current owner's tenure.
    typedef enum logic [1:0] {
        ST_PARK = 2'd0,
        ST_HOLD = 2'd1,
        ST_OVER = 2'd2
    } arb_state_e;

    // Command sent to the slice counter each cycle.
    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_STEP = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/tslice_timer_reg.sv
module tslice_timer_reg #(
    parameter int REG_W     = 8,
    parameter int FIELD_LSB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata
);
    localparam int SLICE_W = REG_W - FIELD_LSB;

    logic [SLICE_W-1:0] field_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= '0;
        end else if (we) begin
            field_q <= wdata[REG_W-1:FIELD_LSB];
        end
    end

    // Reserved low bits are not stored and read back as zero; the result
    // is also the slice length in clocks.
    assign rdata = {field_q, {FIELD_LSB{1'b0}}};

endmodule

// File: rtl/tslice_counter.sv
module tslice_counter
    import tslice_arb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_LOAD: cnt_q <= load_val;
                CNT_STEP: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // The slice is spent once at most one clock of it remains.
    assign done = (cnt_q[CNT_W-1:1] == '0);

endmodule

// File: rtl/tslice_rr_pick.sv
module tslice_rr_pick #(
    parameter int N_AGENTS = 4,
    parameter int IDX_W    = 2
) (
    input  logic [N_AGENTS-1:0] req,
    input  logic [IDX_W-1:0]    owner,
    output logic                any_other,
    output logic [IDX_W-1:0]    next_idx
);
    // Search from the farthest offset down, so the nearest requester
    // after the owner is the one left standing.
    always_comb begin
        any_other = 1'b0;
        next_idx  = owner;
        for (int off = N_AGENTS - 1; off >= 1; off--) begin
            int cand;
            cand = (int'(owner) + off) % N_AGENTS;
            if (req[cand]) begin
                any_other = 1'b1;
                next_idx  = IDX_W'(cand);
            end
        end
    end

endmodule

// File: rtl/tslice_arbiter.sv
module tslice_arbiter
    import tslice_arb_pkg::*;
#(
    parameter int N_AGENTS  = 4,
    parameter int REG_W     = 8,
    parameter int FIELD_LSB = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_AGENTS-1:0] req,
    output logic [N_AGENTS-1:0] gnt,
    input  logic                tmr_we,
    input  logic [REG_W-1:0]    tmr_wdata,
    output logic [REG_W-1:0]    tmr_rdata
);
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;
    localparam int CNT_W = REG_W;

    arb_state_e       state_q, state_nx;
    logic [IDX_W-1:0] owner_q, owner_nx;
    logic [IDX_W-1:0] pick_idx;
    logic             any_other;
    logic             owner_req;
    logic             slice_done;
    logic             handoff;
    cnt_op_e          cnt_op;

    tslice_timer_reg #(
        .REG_W    (REG_W),
        .FIELD_LSB(FIELD_LSB)
    ) u_treg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (tmr_we),
        .wdata(tmr_wdata),
        .rdata(tmr_rdata)
    );

    tslice_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (cnt_op),
        .load_val(tmr_rdata),
        .done    (slice_done)
    );

    tslice_rr_pick #(
        .N_AGENTS(N_AGENTS),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req      (req),
        .owner    (owner_q),
        .any_other(any_other),
        .next_idx (pick_idx)
    );

    assign owner_req = req[owner_q];

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            owner_q <= '0;
        end else begin
            state_q <= state_nx;
            owner_q <= owner_nx;
        end
    end

    // Next state and owner.
    always_comb begin
        state_nx = state_q;
        owner_nx = owner_q;
        handoff  = 1'b0;
        unique case (state_q)
            ST_PARK: begin
                if (any_other && (!owner_req || slice_done)) begin
                    handoff  = 1'b1;                 // T_HANDOFF
                    state_nx = ST_HOLD;
                end else if (owner_req) begin
                    state_nx = slice_done ? ST_OVER  // T_EXPIRE
                                          : ST_HOLD; // T_CLAIM
                end
            end
            ST_HOLD: begin
                if (any_other && (!owner_req || slice_done)) begin
                    handoff  = 1'b1;                 // T_HANDOFF
                end else if (!owner_req) begin
                    state_nx = ST_PARK;              // T_RELEASE
                end else if (slice_done) begin
                    state_nx = ST_OVER;              // T_EXPIRE
                end
            end
            ST_OVER: begin
                if (any_other) begin
                    handoff  = 1'b1;                 // T_HANDOFF
                    state_nx = ST_HOLD;
                end else if (!owner_req) begin
                    state_nx = ST_PARK;              // T_RELEASE
                end
            end
            default: begin
                state_nx = ST_PARK;
            end
        endcase
        if (handoff) begin
            owner_nx = pick_idx;
        end
    end

    // Outputs: counter command and grant decode.
    always_comb begin
        if (handoff || state_nx == ST_PARK) begin
            cnt_op = CNT_LOAD;
        end else if (state_nx == ST_HOLD) begin
            cnt_op = CNT_STEP;
        end else begin
            cnt_op = CNT_IDLE;
        end
    end

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_gnt
        assign gnt[g] = (owner_q == IDX_W'(g));
    end

endmodule

// File: rtl/tslice_arbiter_chk.sv
module tslice_arbiter_chk #(
    parameter int N_AGENTS = 4,
    parameter int REG_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_AGENTS-1:0] req,
    input logic [N_AGENTS-1:0] gnt,
    input logic [REG_W-1:0]    tmr_rdata
);
    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt) == 1);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rdata[2:0] == 3'b000);

    // R7
    idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & ~gnt) == '0) |=> (gnt == $past(gnt)));

    // R6
    drop_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((req & gnt) == '0) && ((req & ~gnt) != '0)) |=> (gnt != $past(gnt)));

    // R5
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != $past(gnt)) |-> (($past(req) & gnt) != '0));

endmodule

bind tslice_arbiter tslice_arbiter_chk #(
    .N_AGENTS(N_AGENTS),
    .REG_W   (REG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .gnt      (gnt),
    .tmr_rdata(tmr_rdata)
);

// File: tb/tslice_arbiter_tb.sv
`timescale 1ns/1ps
module tslice_arbiter_tb;
    localparam int  NA  = 4;
    localparam time CYC = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NA-1:0] req = '0;
    logic [NA-1:0] gnt;
    logic          tmr_we = 1'b0;
    logic [7:0]    tmr_wdata = '0;
    logic [7:0]    tmr_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CYC/2) clk = ~clk;

    tslice_arbiter #(.N_AGENTS(NA)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt),
        .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata)
    );

    // Row fields: we | wdata | req | edges | expected gnt | expected rdata
    localparam int NROW = 21;
    localparam logic [32:0] VEC [0:NROW-1] = '{
        {1'b0, 8'h00, 4'b0000, 8'd2,  4'b0001, 8'h00}, // R7 park, no requests
        {1'b0, 8'h00, 4'b1111, 8'd1,  4'b0010, 8'h00}, // R8 zero slice rotates
        {1'b0, 8'h00, 4'b1111, 8'd1,  4'b0100, 8'h00}, // R8
        {1'b0, 8'h00, 4'b1111, 8'd1,  4'b1000, 8'h00}, // R8
        {1'b0, 8'h00, 4'b1111, 8'd1,  4'b0001, 8'h00}, // R8 R5 wrap
        {1'b1, 8'h13, 4'b0001, 8'd1,  4'b0001, 8'h10}, // R2 R7 lone owner
        {1'b0, 8'h00, 4'b0011, 8'd1,  4'b0010, 8'h10}, // R10 expired yields
        {1'b0, 8'h00, 4'b0011, 8'd15, 4'b0010, 8'h10}, // R4 R9 still in slice
        {1'b0, 8'h00, 4'b0011, 8'd1,  4'b0001, 8'h10}, // R4 slice of 16 ends
        {1'b0, 8'h00, 4'b0101, 8'd3,  4'b0001, 8'h10}, // R4 holds
        {1'b0, 8'h00, 4'b0100, 8'd1,  4'b0100, 8'h10}, // R6 drop moves at once
        {1'b0, 8'h00, 4'b0000, 8'd4,  4'b0100, 8'h10}, // R7 park
        {1'b0, 8'h00, 4'b1111, 8'd16, 4'b1000, 8'h10}, // R5 R9 reload in park
        {1'b0, 8'h00, 4'b1011, 8'd16, 4'b0001, 8'h10}, // R5 wrap skips idle
        {1'b0, 8'h00, 4'b1010, 8'd1,  4'b0010, 8'h10}, // R6 R5
        {1'b1, 8'h08, 4'b1010, 8'd8,  4'b0010, 8'h08}, // R9 old slice kept
        {1'b0, 8'h00, 4'b1010, 8'd8,  4'b1000, 8'h08}, // R4 16 cycles total
        {1'b0, 8'h00, 4'b1010, 8'd8,  4'b0010, 8'h08}, // R9 new slice of 8
        {1'b0, 8'h00, 4'b0010, 8'd20, 4'b0010, 8'h08}, // R7 keeps after expiry
        {1'b0, 8'h00, 4'b0011, 8'd1,  4'b0001, 8'h08}, // R10 R5
        {1'b0, 8'hFF, 4'b0001, 8'd1,  4'b0001, 8'h08}  // R11 write ignored
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CYC * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [32:0] row;
        int          bad_hot;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 gnt in reset", {4'b0, gnt}, 8'h01);
        check("R1 rdata in reset", tmr_rdata, 8'h00);
        rst_n = 1'b1;

        bad_hot = 0;
        for (int r = 0; r < NROW; r++) begin
            row       = VEC[r];
            tmr_we    = row[32];
            tmr_wdata = row[31:24];
            req       = row[23:20];
            for (int e = 0; e < int'(row[19:12]); e++) begin
                @(posedge clk);
                @(negedge clk);
                tmr_we = 1'b0;
                if ($countones(gnt) != 1) bad_hot++;
            end
            check($sformatf("row %0d gnt", r), {4'b0, gnt}, {4'b0, row[11:8]});
            check($sformatf("row %0d rdata", r), tmr_rdata, row[7:0]);
        end
        // R3 one-hot grant across the whole table walk
        check("R3 one-hot violations", 8'(bad_hot), 8'h00);

        // R2 reserved bits read zero after all-ones write
        tmr_we = 1'b1; tmr_wdata = 8'hFF; req = 4'b0000;
        @(posedge clk); @(negedge clk);
        tmr_we = 1'b0;
        check("R2 readback of FFh", tmr_rdata, 8'hF8);

        // R1 reset in mid-run returns grant to agent 0 and clears timer
        req = 4'b1111;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 gnt after mid-run reset", {4'b0, gnt}, 8'h01);
        check("R1 rdata after mid-run reset", tmr_rdata, 8'h00);
        @(negedge clk);
        req = 4'b0000;
        rst_n = 1'b1;

        // R8 zero slice after reset: two agents alternate each edge
        req = 4'b1001;
        @(posedge clk); @(negedge clk);
        check("R8 first edge", {4'b0, gnt}, 8'h08);
        @(posedge clk); @(negedge clk);
        check("R8 second edge", {4'b0, gnt}, 8'h01);
        summary();
    end

endmodule